// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block gathers the interrupt conditions of a serial port channel and presents them to a host as one interrupt request line and a 4-bit identification code. The conditions are: a receive line error, receive data available, receive character timeout, transmit holding register empty, and a change on the CTS/RTS flow-control lines. A 4-bit enable register gates each class of condition. The code always names one source only: the most urgent one that is both pending and enabled.

Some conditions arrive as levels owned by neighbouring logic. These are the line error, receive data available and receive timeout. They fall when that logic is serviced. The other two are held inside this block. Transmit-empty is captured when the holding register becomes empty. It is released when the host writes the holding register, or when the host reads the code while transmit-empty is the source being reported. The flow-control change is captured from a one-cycle event pulse and released by a read of the modem status register. A lower source stays hidden behind a higher one until the higher source is serviced.

Top module: `uirq_ident`

## Requirements
- R1: While reset is asserted, the code is 4'b0001 and the interrupt line is low. The enable register resets to 4'b0010, so only transmit-empty is enabled.
- R2: If the transmit-empty level is high when reset is released, the code becomes 4'b0010 and the interrupt line goes high after the first clock edge.
- R3: Sources are ranked from highest to lowest as follows: line error (code 4'b0110), receive data or timeout, transmit-empty (4'b0010), flow-control change (4'b0000). Only the highest enabled pending source appears in the code.
- R4: Receive data-ready (4'b0100) and receive timeout (4'b1100) share one priority level, and enable bit 0 gates both. When both are present, the code reports data-ready.
- R5: Enable bit 0 gates the receive sources, bit 1 gates transmit-empty, bit 2 gates line error and bit 3 gates flow-control change. A disabled source does not affect the code or the interrupt line. A transmit-empty event held while disabled appears once its enable bit is set again.
- R6: The interrupt line is high exactly when some enabled source is pending. Bit 0 of the code is 1 only when nothing is pending.
- R7: Transmit-empty is captured on a rising edge of the empty level, or when enable bit 1 goes from 0 to 1 while the level is high. It is released by a holding-register write, or by a code read while the code is 4'b0010. A code read that reports any other code leaves it pending.
- R8: A flow-control change pulse captures a pending flag, and a modem-status read releases it. When a pulse and a read fall in the same cycle, the flag stays set.
- R9: The code and the interrupt line are registered. They reflect the inputs and strobes of a cycle after the following clock edge.
- R10: A code read releases transmit-empty if transmit-empty was the reported code at the time of the read. This holds even when a higher source arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 4 | New enable register value |
| line_err_i | input | 1 | Receive line error level |
| rx_rdy_i | input | 1 | Receive data available level |
| rx_to_i | input | 1 | Receive character timeout level |
| txe_lvl_i | input | 1 | Transmit holding register empty level |
| flow_evt_i | input | 1 | One-cycle pulse on a CTS/RTS change |
| thr_wr_i | input | 1 | Host write of the transmit holding register |
| id_rd_i | input | 1 | Host read of the identification code |
| msr_rd_i | input | 1 | Host read of the modem status register |
| irq_o | output | 1 | Interrupt request, active high |
| id_o | output | 4 | Identification code of the highest pending source |

## Verification
The collision of interest is a code read that releases transmit-empty in the same cycle that a line error rises. The bench drives the read strobe and the error level together while 4'b0010 is showing. It expects the line-error code on the next edge, and an idle code once the error drops, which proves the read released the transmit flag. A flow-control pulse that coincides with a modem-status read is also driven directly, and the flag must survive. The random phase mixes all strobes freely against a cycle-accurate bench model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int EN_W   = 4;
    localparam int CODE_W = 4;

    // enable bit positions
    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [EN_W-1:0]   en_t;

    localparam code_t ID_NONE = 4'b0001;
    localparam code_t ID_LINE = 4'b0110;
    localparam code_t ID_RXD  = 4'b0100;
    localparam code_t ID_RXTO = 4'b1100;
    localparam code_t ID_TXE  = 4'b0010;
    localparam code_t ID_FLOW = 4'b0000;

    localparam en_t EN_RST = 4'b0010;

    typedef struct packed {
        logic line;
        logic rxd;
        logic rxto;
        logic txe;
        logic flow;
    } req_t;
endpackage

// File: rtl/uirq_pend.sv
module uirq_pend #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_nxt_o,
    output logic pend_o
);
    logic pend_d, pend_q;

    generate
        if (SET_WINS) begin : g_set_first
            always_comb begin
                pend_d = pend_q;
                if (clr_i) pend_d = 1'b0;
                if (set_i) pend_d = 1'b1;
            end
        end else begin : g_clr_first
            always_comb begin
                pend_d = pend_q;
                if (set_i) pend_d = 1'b1;
                if (clr_i) pend_d = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_nxt_o = pend_d;
    assign pend_o     = pend_q;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  req_t  req_i,
    output code_t code_o,
    output logic  any_o
);
    always_comb begin
        code_o = ID_NONE;
        if (req_i.line)      code_o = ID_LINE;
        else if (req_i.rxd)  code_o = ID_RXD;
        else if (req_i.rxto) code_o = ID_RXTO;
        else if (req_i.txe)  code_o = ID_TXE;
        else if (req_i.flow) code_o = ID_FLOW;
        any_o = |req_i;
    end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we_i,
    input  logic [EN_W-1:0] en_wdata_i,
    input  logic            line_err_i,
    input  logic            rx_rdy_i,
    input  logic            rx_to_i,
    input  logic            txe_lvl_i,
    input  logic            flow_evt_i,
    input  logic            thr_wr_i,
    input  logic            id_rd_i,
    input  logic            msr_rd_i,
    output logic            irq_o,
    output logic [CODE_W-1:0] id_o
);
    typedef struct packed {
        en_t   en;
        logic  txe_prev;
        code_t code;
        logic  irq;
    } state_t;

    state_t s_d, s_q;
    logic   txe_set, txe_clr, txe_nxt, txe_pend;
    logic   flow_nxt, flow_pend;
    req_t   req;
    code_t  prio_code;
    logic   prio_any;
    en_t    en_nxt;

    // enable register next value, shared by gating and edge capture
    assign en_nxt  = en_we_i ? en_wdata_i : s_q.en;
    assign txe_set = txe_lvl_i & (~s_q.txe_prev | (~s_q.en[EN_TX] & en_nxt[EN_TX]));
    assign txe_clr = thr_wr_i | (id_rd_i & (s_q.code == ID_TXE));

    uirq_pend #(.SET_WINS(1'b1)) txe_pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (txe_set),
        .clr_i      (txe_clr),
        .pend_nxt_o (txe_nxt),
        .pend_o     (txe_pend)
    );

    uirq_pend #(.SET_WINS(1'b1)) flow_pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (flow_evt_i),
        .clr_i      (msr_rd_i),
        .pend_nxt_o (flow_nxt),
        .pend_o     (flow_pend)
    );

    always_comb begin
        req.line = line_err_i & en_nxt[EN_LS];
        req.rxd  = rx_rdy_i   & en_nxt[EN_RX];
        req.rxto = rx_to_i    & en_nxt[EN_RX];
        req.txe  = txe_nxt    & en_nxt[EN_TX];
        req.flow = flow_nxt   & en_nxt[EN_MS];
    end

    uirq_prio prio_i (
        .req_i  (req),
        .code_o (prio_code),
        .any_o  (prio_any)
    );

    always_comb begin
        s_d          = s_q;
        s_d.en       = en_nxt;
        s_d.txe_prev = txe_lvl_i;
        s_d.code     = prio_code;
        s_d.irq      = prio_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en       <= EN_RST;
            s_q.txe_prev <= 1'b0;
            s_q.code     <= ID_NONE;
            s_q.irq      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;
    assign id_o  = s_q.code;

    logic unused_pend;
    assign unused_pend = txe_pend ^ flow_pend;
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk
    import uirq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            en_we_i,
    input logic [EN_W-1:0] en_wdata_i,
    input logic            line_err_i,
    input logic            rx_rdy_i,
    input logic            txe_lvl_i,
    input logic            flow_evt_i,
    input logic            thr_wr_i,
    input logic            msr_rd_i,
    input logic            irq_o,
    input logic [CODE_W-1:0] id_o
);
    // R6
    irq_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (id_o != ID_NONE));

    // R7
    txe_write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_i && !txe_lvl_i |=> id_o != ID_TXE);

    // R8
    flow_read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msr_rd_i && !flow_evt_i |=> id_o != ID_FLOW);

    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_err_i && en_we_i && en_wdata_i[EN_LS] |=> id_o == ID_LINE);

    // R4
    rx_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i && en_wdata_i[EN_RX] && rx_rdy_i && !(line_err_i && en_wdata_i[EN_LS])
        |=> id_o == ID_RXD);

    // R5
    rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i && !en_wdata_i[EN_RX] |=> (id_o != ID_RXD) && (id_o != ID_RXTO));
endmodule

bind uirq_ident uirq_ident_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .line_err_i (line_err_i),
    .rx_rdy_i   (rx_rdy_i),
    .txe_lvl_i  (txe_lvl_i),
    .flow_evt_i (flow_evt_i),
    .thr_wr_i   (thr_wr_i),
    .msr_rd_i   (msr_rd_i),
    .irq_o      (irq_o),
    .id_o       (id_o)
);

// File: tb/uirq_ident_tb_top.sv
module uirq_ident_tb_top;
    import uirq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_we = 1'b0;
    logic [EN_W-1:0] en_wd = '0;
    logic line_err = 1'b0, rx_rdy = 1'b0, rx_to = 1'b0, txe_lvl = 1'b1;
    logic flow_evt = 1'b0, thr_wr = 1'b0, id_rd = 1'b0, msr_rd = 1'b0;
    logic irq;
    logic [CODE_W-1:0] id;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uirq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .en_we_i(en_we), .en_wdata_i(en_wd),
        .line_err_i(line_err), .rx_rdy_i(rx_rdy), .rx_to_i(rx_to),
        .txe_lvl_i(txe_lvl), .flow_evt_i(flow_evt), .thr_wr_i(thr_wr),
        .id_rd_i(id_rd), .msr_rd_i(msr_rd), .irq_o(irq), .id_o(id)
    );

    // bench reference model of the requirements
    logic [3:0] m_en;
    logic m_txp, m_flp, m_prev, m_irq;
    logic [3:0] m_code;

    function automatic logic [3:0] rank(input logic [3:0] en, input logic le,
        input logic rd, input logic rt, input logic tp, input logic fp);
        if (le && en[2]) return 4'b0110;
        if (rd && en[0]) return 4'b0100;
        if (rt && en[0]) return 4'b1100;
        if (tp && en[1]) return 4'b0010;
        if (fp && en[3]) return 4'b0000;
        return 4'b0001;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 4'b0010; m_txp = 0; m_flp = 0; m_prev = 0;
            m_code = 4'b0001; m_irq = 0;
        end else begin
            logic [3:0] en_n;
            logic rise;
            en_n = en_we ? en_wd : m_en;
            rise = txe_lvl && (!m_prev || (!m_en[1] && en_n[1]));
            if (thr_wr || (id_rd && m_code == 4'b0010)) m_txp = 0;
            if (rise) m_txp = 1;
            if (msr_rd) m_flp = 0;
            if (flow_evt) m_flp = 1;
            m_prev = txe_lvl;
            m_en = en_n;
            m_code = rank(m_en, line_err, rx_rdy, rx_to, m_txp, m_flp);
            m_irq = (m_code != 4'b0001);
        end
    end

    task automatic chk(input string tag, input logic [3:0] exp);
        total++;
        if (id !== exp || irq !== (exp != 4'b0001)) begin
            bad++;
            $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b", tag, id, irq, exp, exp != 4'b0001);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        en_we = 0; flow_evt = 0; thr_wr = 0; id_rd = 0; msr_rd = 0;
    endtask

    task automatic wr_en(input logic [3:0] v);
        en_we = 1; en_wd = v;
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0110: return "R3";
            4'b0100, 4'b1100: return "R4";
            4'b0010: return "R7";
            4'b0000: return "R8";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 4'b0001);
        rst_n = 1;
        tick(); chk("R2 empty after reset", 4'b0010);
        id_rd = 1; tick(); chk("R7 code read releases", 4'b0001);
        txe_lvl = 0; tick(); chk("R7 idle", 4'b0001);
        txe_lvl = 1; tick(); chk("R7 rising edge", 4'b0010);
        thr_wr = 1; txe_lvl = 0; tick(); chk("R7 write releases", 4'b0001);
        wr_en(4'b1111); line_err = 1; rx_rdy = 1; rx_to = 1; flow_evt = 1; txe_lvl = 1;
        tick(); chk("R3 line first", 4'b0110);
        line_err = 0; tick(); chk("R4 tie data", 4'b0100);
        rx_rdy = 0; tick(); chk("R4 timeout", 4'b1100);
        rx_to = 0; tick(); chk("R3 tx next", 4'b0010);
        thr_wr = 1; tick(); chk("R3 flow last", 4'b0000);
        flow_evt = 1; msr_rd = 1; tick(); chk("R8 set wins", 4'b0000);
        msr_rd = 1; tick(); chk("R8 read releases", 4'b0001);
        line_err = 1; wr_en(4'b1011); tick(); chk("R5 line gated", 4'b0001);
        wr_en(4'b1111); tick(); chk("R5 line enabled", 4'b0110);
        line_err = 0; wr_en(4'b1101); tick(); chk("R5 idle", 4'b0001);
        txe_lvl = 0; tick();
        txe_lvl = 1; tick(); chk("R5 tx gated", 4'b0001);
        wr_en(4'b1111); tick(); chk("R5 held tx shows", 4'b0010);
        id_rd = 1; line_err = 1; tick(); chk("R10 collision", 4'b0110);
        line_err = 0; tick(); chk("R10 tx released", 4'b0001);
        wr_en(4'b1101); tick(); chk("R7 idle", 4'b0001);
        wr_en(4'b1111); tick(); chk("R7 enable edge", 4'b0010);
        line_err = 1; #1; chk("R9 not yet", 4'b0010);
        tick(); chk("R9 after edge", 4'b0110);
        line_err = 0; tick();
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            en_we = ($urandom % 10) == 0; en_wd = 4'($urandom);
            line_err = ($urandom % 10) == 0;
            rx_rdy = ($urandom % 3) == 0;
            rx_to = ($urandom % 6) == 0;
            if (($urandom % 4) == 0) txe_lvl = ~txe_lvl;
            flow_evt = ($urandom % 10) == 0;
            thr_wr = ($urandom % 7) == 0;
            id_rd = ($urandom % 5) == 0;
            msr_rd = ($urandom % 7) == 0;
            @(posedge clk); @(negedge clk);
            chk(tag_of(m_code), m_code);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule